// File: doc/BRIEF.md
# Host Register Access Slave

This block lets a host processor program and inspect a network MAC through a small register file. It runs entirely on the host clock and talks to the host over a strobe-level handshake. Chip select, a write strobe and a read strobe are all active low. An active-low ready output closes each transfer. The host must hold its control, address and write data steady until ready falls. Ready then stays low for as long as the host keeps the request asserted. A new transfer begins only after the request has been released.

The block holds two configuration registers and one read-only status word. The configuration registers are an operating-mode word and a transmit/receive control word, and bit 0 of the control word enables the receiver. The receive logic loads the status word through its own update port. Because each transfer is held open until ready answers it, the host side needs no valid/ready stream. Every data movement is one strobe-framed access.

Top module: `hreg_host_if`

## Requirements
- R1: After an active-low reset, host_ready_n is 1, host_dout is 0, the mode, control and status registers are 0, and rx_en_o is 0.
- R2: A write request is host_cs_n=0, host_wr_n=0 and host_rd_n=1 while ready is high. At the sampling clock edge, host_din is stored into the register at host_addr, and host_ready_n is 0 after that edge. The map is mode at address 0, control at 1 and status at 2.
- R3: While ready is low and the host keeps chip select and the active strobe asserted, ready stays low and no further transfer takes place. At the first edge where chip select or the active strobe is high, ready returns to 1.
- R4: A read request is host_cs_n=0, host_rd_n=0 and host_wr_n=1 while ready is high. After the sampling edge, host_dout carries the addressed register and host_ready_n is 0, and both hold for as long as ready stays low.
- R5: host_dout is 0 whenever host_ready_n is 1.
- R6: If chip select and both strobes are low at the same time, no register changes and ready stays high.
- R7: A read of any address other than 0, 1 or 2 returns 0. A write to such an address is acknowledged and changes no register.
- R8: A host write to the status address is acknowledged but ignored. When rx_stat_we is 1 at a clock edge, the status register loads rx_stat_in.
- R9: mode_o and ctrl_o present the stored registers. rx_en_o equals bit 0 of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_addr | input | ADDR_W | Register address |
| host_din | input | DATA_W | Write data |
| host_dout | output | DATA_W | Read data, valid while ready is low |
| host_ready_n | output | 1 | Transfer acknowledge, active low |
| rx_stat_we | input | 1 | Status load strobe from receive logic |
| rx_stat_in | input | DATA_W | Status value from receive logic |
| mode_o | output | DATA_W | Mode register contents |
| ctrl_o | output | DATA_W | Transmit/receive control register contents |
| rx_en_o | output | 1 | Receiver enable (control bit 0) |

## Verification
A stuck handshake state shows up at the ports on the first clock after the host acts. The symptom is either a ready that never falls after a request, or one that does not rise after release. A decode or storage fault shows up at mode_o, ctrl_o or rx_en_o one clock after the faulty write. On a read, the same fault is seen in the data returned with ready. A read-data register that is not cleared is exposed by the first cycle in which ready is high while host_dout is nonzero.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_t;
endpackage

// File: rtl/hreg_handshake.sv
module hreg_handshake
  import hreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_fire,
  output logic rd_fire,
  output logic xfer_end,
  output logic ready_n
);
  hs_state_t st;
  logic      ready_q;
  logic      op_rd;
  logic      wr_req, rd_req, release_w;

  assign wr_req    = !cs_n && !wr_n && rd_n;
  assign rd_req    = !cs_n && !rd_n && wr_n;
  assign release_w = cs_n || (op_rd ? rd_n : wr_n);

  assign wr_fire  = (st == HS_IDLE) && wr_req;
  assign rd_fire  = (st == HS_IDLE) && rd_req;
  assign xfer_end = (st == HS_ACK) && release_w;
  assign ready_n  = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= HS_IDLE;
      ready_q <= 1'b1;
      op_rd   <= 1'b0;
    end else begin
      case (st)
        HS_IDLE: if (wr_req || rd_req) begin
          st      <= HS_ACK;
          ready_q <= 1'b0;
          op_rd   <= rd_req;
        end
        HS_ACK: if (release_w) begin
          st      <= HS_IDLE;
          ready_q <= 1'b1;
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  // R2 / R4: a single clean request while idle is acknowledged next clock
  p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !cs_n && (wr_n != rd_n)) |=> !ready_q);

  // R6: both strobes together never produce an acknowledge
  p_no_ack_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !cs_n && !wr_n && !rd_n) |=> ready_q);

  // R3: dropping chip select ends the transfer one clock later
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && cs_n) |=> ready_q);
endmodule

// File: rtl/hreg_regfile.sv
module hreg_regfile #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int MODE_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic              xfer_end,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] stat_in,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] dout
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] dout_q;
  logic              hit_mode, hit_ctrl, hit_stat;

  assign hit_mode = (addr == A_MODE);
  assign hit_ctrl = (addr == A_CTRL);
  assign hit_stat = (addr == A_STAT);

  always_comb begin
    rd_sel = '0;
    if (hit_mode) rd_sel = mode_q;
    if (hit_ctrl) rd_sel = ctrl_q;
    if (hit_stat) rd_sel = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else if (wr_fire) begin
      if (hit_mode) mode_q <= din;
      if (hit_ctrl) ctrl_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= stat_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (rd_fire)  dout_q <= rd_sel;
    else if (xfer_end) dout_q <= '0;
  end

  assign dout = dout_q;

  // R8: host writes never reach the status word
  p_stat_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hit_stat && !stat_we) |=> $stable(stat_q));

  // R7: writes outside the map leave configuration untouched
  p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !hit_mode && !hit_ctrl && !hit_stat) |=> ($stable(mode_q) && $stable(ctrl_q)));
endmodule

// File: rtl/hreg_host_if.sv
module hreg_host_if #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int MODE_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_wr_n,
  input  logic              host_rd_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_ready_n,
  input  logic              rx_stat_we,
  input  logic [DATA_W-1:0] rx_stat_in,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              rx_en_o
);
  logic wr_fire, rd_fire, xfer_end;

  hreg_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (host_cs_n),
    .wr_n     (host_wr_n),
    .rd_n     (host_rd_n),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .xfer_end (xfer_end),
    .ready_n  (host_ready_n)
  );

  hreg_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_ADDR (MODE_ADDR),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .xfer_end (xfer_end),
    .addr     (host_addr),
    .din      (host_din),
    .stat_we  (rx_stat_we),
    .stat_in  (rx_stat_in),
    .mode_q   (mode_o),
    .ctrl_q   (ctrl_o),
    .dout     (host_dout)
  );

  assign rx_en_o = ctrl_o[0];

  // R5: read data is zero whenever no acknowledge is shown
  p_dout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready_n |-> (host_dout == '0));

  // R9: receiver enable follows control bit 0
  p_rx_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_o == ctrl_o[0]);
endmodule

// File: tb/hreg_host_if_bench.sv
module hreg_host_if_bench;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          ready_n;
  logic          st_we = 1'b0;
  logic [DW-1:0] st_in = '0;
  logic [DW-1:0] mode_o, ctrl_o;
  logic          rx_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hreg_host_if u_hreg_host_if (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(cs_n), .host_wr_n(wr_n), .host_rd_n(rd_n),
    .host_addr(addr), .host_din(din), .host_dout(dout), .host_ready_n(ready_n),
    .rx_stat_we(st_we), .rx_stat_in(st_in),
    .mode_o(mode_o), .ctrl_o(ctrl_o), .rx_en_o(rx_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Request at negedge, sample point is the next negedge after the edge
  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 0; wr_n = 0; rd_n = 1;
    @(negedge clk);
    chk("R2 write ack", ready_n, 0);
    cs_n = 1; wr_n = 1;
    @(negedge clk);
    chk("R3 ready release", ready_n, 1);
  endtask

  task automatic host_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    addr = a; cs_n = 0; rd_n = 0; wr_n = 1;
    @(negedge clk);
    chk({req, " ready"}, ready_n, 0);
    chk({req, " data"}, dout, exp);
    @(negedge clk);
    chk("R4 data held", dout, exp);
    cs_n = 1; rd_n = 1;
    @(negedge clk);
    chk("R5 dout idle", dout, 0);
    chk("R3 ready release", ready_n, 1);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready_n, 1);
    chk("R1 dout", dout, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 rx_en", rx_en, 0);
    host_read(2, 16'h0, "R1 status");
  endtask

  task automatic t_write_read();
    host_write(0, 16'hA5C3);
    chk("R9 mode_o", mode_o, 16'hA5C3);
    host_write(1, 16'h0001);
    chk("R9 ctrl_o", ctrl_o, 16'h0001);
    chk("R9 rx_en", rx_en, 1);
    host_read(0, 16'hA5C3, "R4 mode");
    host_read(1, 16'h0001, "R4 ctrl");
    host_write(1, 16'h7FFE);
    chk("R9 rx_en off", rx_en, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    addr = 0; din = 16'h1234; cs_n = 0; wr_n = 0; rd_n = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 ready held", ready_n, 0);
    end
    chk("R2 held write", mode_o, 16'h1234);
    wr_n = 1; // release strobe only
    @(negedge clk);
    chk("R3 strobe release", ready_n, 1);
    cs_n = 1;
    @(negedge clk);
  endtask

  task automatic t_both();
    @(negedge clk);
    addr = 0; din = 16'hFFFF; cs_n = 0; wr_n = 0; rd_n = 0;
    @(negedge clk);
    chk("R6 no ack", ready_n, 1);
    @(negedge clk);
    chk("R6 no ack 2", ready_n, 1);
    chk("R6 mode kept", mode_o, 16'h1234);
    cs_n = 1; wr_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic t_unmapped();
    host_write(5, 16'hBEEF);
    chk("R7 mode kept", mode_o, 16'h1234);
    chk("R7 ctrl kept", ctrl_o, 16'h7FFE);
    host_read(5, 16'h0, "R7 unmapped read");
    host_read(15, 16'h0, "R7 top read");
  endtask

  task automatic t_status();
    host_write(2, 16'hDEAD);
    host_read(2, 16'h0, "R8 host write ignored");
    @(negedge clk);
    st_we = 1; st_in = 16'h0C3A;
    @(negedge clk);
    st_we = 0; st_in = 16'hFFFF;
    host_read(2, 16'h0C3A, "R8 status load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hold();
    t_both();
    t_unmapped();
    t_status();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule